// File: doc/BRIEF.md
# Bus Watchpoint Comparator Unit

The unit observes accesses on a 16-bit processor bus with a 24-bit address. For each observed access it decides, per channel, whether the access meets that channel's programmed criteria. There are four comparator channels. Each one compares the full address. Each can optionally check the access direction and the access width (byte or word). The even channels (0 and 2) also compare the bus data under a per-bit mask, and that data result can be inverted so the channel fires when the data differs. The odd channels (1 and 3) have no data comparator, so bit 7 of their control byte gives the expected access width instead.

Software programs the channels through a byte-wide window of eight offsets, and a channel-select input picks which channel's bytes the window shows. Registers can be read at any time. Writes are refused while the unit is armed. Each channel reports a single-cycle hit on its own output one clock after a qualifying access. A control bit named tag turns off both the width check and the data inversion for its channel. The source and break bits are stored but have no effect inside this unit.

Top module: `bus_watch_cmp`

## Requirements
- R1: After reset every window byte of every channel reads 0 and `hit` is 0.
- R2: Window offsets are 0 control, 1 address[23:16], 2 address[15:8], 3 address[7:0], 4 data[15:8], 5 data[7:0], 6 mask[15:8], 7 mask[7:0]. `cfg_sel` selects the channel, and reads are combinational. On odd channels, offsets 4 to 7 read 0 and writes to them are ignored.
- R3: A write presented while `arm` is 1 leaves the addressed byte unchanged.
- R4: `hit[n]` is 1 in the cycle after a valid access in which `arm` was 1, control bit 0 (enable) was 1 and `bus_addr` equalled all 24 stored address bits, with the other enabled criteria also met. Otherwise `hit[n]` is 0, so each qualifying access gives exactly a one-cycle pulse.
- R5: No hit occurs while `arm` is 0, while the enable bit is 0, or when `bus_valid` is 0.
- R6: On even channels, a mask bit of 1 includes that data bit in the comparison and a mask bit of 0 excludes it. With inversion off, the data criterion holds when all included bits are equal.
- R7: On even channels, control bit 7 set with bit 5 clear inverts the masked data result. The channel then fires only when some included bit differs.
- R8: Control bit 6 set with bit 5 clear requires the access width to match. `bus_word`=1 means word. Odd channels expect the width given by control bit 7 (1 = word), and even channels expect a word.
- R9: Control bit 5 (tag) set disables both the width check of R8 and the inversion of R7.
- R10: Control bit 2 set requires `bus_rd` to equal control bit 3 (1 = read). When bit 2 is clear, the direction is ignored.
- R11: Control bits 1 and 4 are read back as written and have no effect on any hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Unit armed; enables hits and blocks writes |
| cfg_sel | input | 2 | Channel shown in the window |
| cfg_off | input | 3 | Byte offset within the window |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected byte |
| bus_valid | input | 1 | An access is present this cycle |
| bus_addr | input | 24 | Access address |
| bus_data | input | 16 | Access data |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_rd | input | 1 | 1 = read, 0 = write |
| hit | output | 4 | Per-channel match pulse |

## Verification
The assertions assume that `arm` and the bus inputs are steady during each clock cycle, and that the reset is held for at least one edge before the first access. The stimulus meets these assumptions by changing every input only on the falling edge. It raises `arm` only after configuration is finished, and it drops `arm` before any further register write, so the write lock is exercised only on purpose. The sweeps cover every combination of the seven upper control bits on every channel. For each combination they use three data patterns, both widths, both directions, and an address hit and miss, and the expected hit vector comes from a model built from the requirements.

// File: rtl/bus_watch_cmp.sv
module bus_watch_cmp #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm,
  input  logic [$clog2(NCH)-1:0] cfg_sel,
  input  logic [2:0]             cfg_off,
  input  logic                   cfg_we,
  input  logic [7:0]             cfg_wdata,
  output logic [7:0]             cfg_rdata,
  input  logic                   bus_valid,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_data,
  input  logic                   bus_word,
  input  logic                   bus_rd,
  output logic [NCH-1:0]         hit
);
  localparam int WIN = 8;

  logic [7:0]           win [NCH][WIN];
  logic [NCH*WIN*8-1:0] win_flat;
  logic [NCH-1:0]       hit_d;
  logic                 hole;

  assign hole = cfg_sel[0] & cfg_off[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < WIN; k++)
          win[c][k] <= '0;
    end else if (cfg_we && !arm && !hole) begin
      win[cfg_sel][cfg_off] <= cfg_wdata;
    end
  end

  assign cfg_rdata = hole ? 8'h00 : win[cfg_sel][cfg_off];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [7:0] ctl;
    logic       addr_ok, rw_ok, sz_want, sz_ok, data_ok;

    assign ctl     = win[g][0];
    assign addr_ok = bus_addr == {win[g][1], win[g][2], win[g][3]};
    assign rw_ok   = !ctl[2] || (bus_rd == ctl[3]);
    assign sz_ok   = !(ctl[6] && !ctl[5]) || (bus_word == sz_want);

    if (g % 2 == 0) begin : g_data
      logic [DATA_W-1:0] ref_d, msk;
      logic              same;
      assign ref_d   = {win[g][4], win[g][5]};
      assign msk     = {win[g][6], win[g][7]};
      assign same    = ((bus_data ^ ref_d) & msk) == '0;
      assign data_ok = same ^ (ctl[7] & ~ctl[5]);
      assign sz_want = 1'b1;
    end else begin : g_nodata
      assign data_ok = 1'b1;
      assign sz_want = ctl[7];
    end

    assign hit_d[g] = arm & bus_valid & ctl[0] & addr_ok & rw_ok & sz_ok & data_ok;

    for (genvar k = 0; k < WIN; k++) begin : g_flat
      assign win_flat[(g*WIN+k)*8 +: 8] = win[g][k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hit <= '0;
    else        hit <= hit_d;
  end
endmodule

module bus_watch_cmp_chk #(
  parameter int NCH = 4,
  parameter int WB  = NCH*64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   arm,
  input logic                   bus_valid,
  input logic                   bus_word,
  input logic                   bus_rd,
  input logic [$clog2(NCH)-1:0] cfg_sel,
  input logic [2:0]             cfg_off,
  input logic [7:0]             cfg_rdata,
  input logic [NCH-1:0]         hit,
  input logic [WB-1:0]          win_flat
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> hit == '0);

  // R2
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel[0] && cfg_off[2]) |-> cfg_rdata == 8'h00);

  // R3
  write_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> $stable(win_flat));

  // R5
  qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |-> ($past(arm) && $past(bus_valid)));

  // R8
  width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && $past(win_flat[64+6]) && !$past(win_flat[64+5]))
      |-> $past(bus_word) == $past(win_flat[64+7]));

  // R10
  direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && $past(win_flat[2])) |-> $past(bus_rd) == $past(win_flat[3]));

  for (genvar g = 0; g < NCH; g++) begin : g_en
    // R4
    enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |-> $past(win_flat[g*64]));
  end
endmodule

bind bus_watch_cmp bus_watch_cmp_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .bus_valid(bus_valid),
  .bus_word(bus_word), .bus_rd(bus_rd), .cfg_sel(cfg_sel), .cfg_off(cfg_off),
  .cfg_rdata(cfg_rdata), .hit(hit), .win_flat(win_flat)
);

// File: tb/bus_watch_cmp_test.sv
module bus_watch_cmp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [2:0]  cfg_off = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        bus_valid = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        bus_word = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  hit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] sh [4][8];

  always #2.5 clk = ~clk;

  bus_watch_cmp uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_sel(cfg_sel), .cfg_off(cfg_off),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_word(bus_word), .bus_rd(bus_rd), .hit(hit)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int off, logic [7:0] v);
    @(negedge clk);
    cfg_sel = 2'(ch); cfg_off = 3'(off); cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!arm && !((ch % 2 == 1) && off >= 4)) sh[ch][off] = v;
  endtask

  task automatic rd(int ch, int off, string req);
    logic [7:0] e;
    @(negedge clk);
    cfg_sel = 2'(ch); cfg_off = 3'(off);
    #1;
    e = ((ch % 2 == 1) && off >= 4) ? 8'h00 : sh[ch][off];
    chk(cfg_rdata == e, req, cfg_rdata, e);
  endtask

  function automatic bit model(int ch, logic [23:0] a, logic [15:0] d, bit w, bit r, bit v);
    logic [7:0] c;
    bit want, same;
    c = sh[ch][0];
    if (!v || !arm || !c[0]) return 0;
    if (a != {sh[ch][1], sh[ch][2], sh[ch][3]}) return 0;
    if (c[2] && (r != c[3])) return 0;
    want = (ch % 2 == 0) ? 1'b1 : c[7];
    if (c[6] && !c[5] && (w != want)) return 0;
    if (ch % 2 == 1) return 1;
    same = ((d ^ {sh[ch][4], sh[ch][5]}) & {sh[ch][6], sh[ch][7]}) == 16'h0;
    if (c[7] && !c[5]) return !same;
    return same;
  endfunction

  function automatic string label(int ch);
    logic [7:0] c;
    c = sh[ch][0];
    if (c[5]) return "R9";
    if (c[7] && ch % 2 == 0) return "R7";
    if (c[6]) return "R8";
    if (c[2]) return "R10";
    if (c[1] || c[4]) return "R11";
    return (ch % 2 == 0) ? "R6" : "R4";
  endfunction

  task automatic access(logic [23:0] a, logic [15:0] d, bit w, bit r, bit v, string req);
    logic [3:0] e;
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_word = w; bus_rd = r; bus_valid = v;
    for (int c = 0; c < 4; c++) e[c] = model(c, a, d, w, r, v);
    @(negedge clk);
    bus_valid = 1'b0;
    chk(hit == e, req, hit, e);
  endtask

  function automatic logic [23:0] base(int ch);
    return {8'(8'h10 + ch), 8'(8'h5A ^ ch), 8'(8'hC3 + ch)};
  endfunction

  initial begin
    for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) sh[c][k] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hit == 4'h0, "R1", hit, 0);
    for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) rd(c, k, "R1");

    // R2, R11: every byte written and read back, holes stay zero
    for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) wr(c, k, 8'(c*37 + k*11 + 5));
    for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) rd(c, k, "R2");
    wr(1, 0, 8'h12);
    rd(1, 0, "R11");

    // R3: writes while armed are dropped
    arm = 1'b1;
    for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) wr(c, k, 8'hFF);
    arm = 1'b0;
    for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) rd(c, k, "R3");

    for (int c = 0; c < 4; c++) begin
      wr(c, 0, 8'h00);
      wr(c, 1, base(c)[23:16]); wr(c, 2, base(c)[15:8]); wr(c, 3, base(c)[7:0]);
      if (c % 2 == 0) begin
        wr(c, 4, 8'h12); wr(c, 5, 8'h34); wr(c, 6, 8'h0F); wr(c, 7, 8'hF0);
      end
    end

    // R4..R11 sweep: all upper control combinations on every channel
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 128; m++) begin
        arm = 1'b0;
        wr(c, 0, {7'(m), 1'b1});
        arm = 1'b1;
        for (int dp = 0; dp < 3; dp++)
          for (int w = 0; w < 2; w++)
            for (int r = 0; r < 2; r++)
              for (int miss = 0; miss < 2; miss++) begin
                logic [15:0] d;
                d = (dp == 0) ? 16'h1234 : (dp == 1) ? 16'h1A34 : 16'hF23F;
                access(base(c) ^ 24'(miss << (m % 24)), d, w[0], r[0], 1'b1, label(c));
              end
      end
      arm = 1'b0;
      wr(c, 0, 8'h00);
    end

    // R4: single-bit address misses and a one-cycle pulse
    arm = 1'b0;
    wr(0, 0, 8'h01);
    arm = 1'b1;
    for (int b = 0; b < 24; b++) access(base(0) ^ (24'h1 << b), 16'h1234, 1'b1, 1'b0, 1'b1, "R4");
    access(base(0), 16'h1234, 1'b1, 1'b0, 1'b1, "R4");
    @(negedge clk);
    chk(hit == 4'h0, "R4", hit, 0);

    // R5: disarmed, invalid, disabled
    access(base(0), 16'h1234, 1'b1, 1'b0, 1'b0, "R5");
    arm = 1'b0;
    access(base(0), 16'h1234, 1'b1, 1'b0, 1'b1, "R5");
    wr(0, 0, 8'h00);
    arm = 1'b1;
    access(base(0), 16'h1234, 1'b1, 1'b0, 1'b1, "R5");
    arm = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule